// File: doc/BRIEF.md
# Two-Stage UART Bit-Rate Generator

This block derives UART bit timing from the system clock in two stages. A power-of-two prescaler, set by a 4-bit clock-select value k, produces a basic-clock enable once every 2^k system cycles. A second stage counts N of these basic enables, where N is an 8-bit divisor. Each terminal count toggles a final divide-by-two. The result is a bit-period tick every 2·N·2^k system cycles, and a mid-bit tick halfway through each period for the receiver's sampling point.

Both settings are written over a small byte bus. Any write restarts the generator from zero. So does holding the channel enable low. A ready flag tells the surrounding UART when the settling time of two basic clocks has passed since the last restart, so that the transmitter and receiver may be switched on again. Every output is a single-cycle enable in the system clock domain.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, basic_tick, mid_tick, bit_tick and ready are all 0.
- R2: A write with wr_addr=0 loads the clock select from wr_data[3:0]. With effective select k, basic_tick pulses once every 2^k cycles, and the first pulse comes 2^k cycles after a restart.
- R3: A write with wr_addr=1 loads the divisor N from wr_data[7:0]. bit_tick pulses on every 2N-th basic_tick, so the first pulse comes 2·N·2^k cycles after a restart and the pulses repeat every 2·N·2^k cycles.
- R4: mid_tick pulses on the N-th basic_tick of each bit period, that is N·2^k and 3·N·2^k cycles after a restart. It never pulses in the same cycle as bit_tick.
- R5: A divisor written below 8 acts as 8.
- R6: A select written above 11 acts as 11. A select below the smallest value that keeps the basic clock at or below MAX_BASIC_HZ (1 with the default 50 MHz system clock and 25 MHz limit) is raised to that value.
- R7: A write to either register restarts the prescaler, the divisor counter and the half-period phase. The cycle after the write edge counts as cycle 0.
- R8: While chan_en is low, all four outputs stay 0. The cycle in which chan_en is first seen high counts as cycle 0.
- R9: ready goes high together with the second basic_tick after a restart, at cycle 2·2^k. It is cleared by every restart.
- R10: bit_tick never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low holds the generator cleared |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the clock select, 1 selects the divisor |
| wr_data | input | 8 | Write data |
| basic_tick | output | 1 | Prescaled basic-clock enable |
| mid_tick | output | 1 | Mid-bit sampling enable |
| bit_tick | output | 1 | Bit-period enable |
| ready | output | 1 | Two basic clocks have elapsed since restart |

## Verification
A vector table walks select/divisor pairs with different shapes. Some use small selects with the minimum divisor, which separates the prescaler period from the divisor period. Some use odd divisors such as 9 and 13, which expose off-by-one errors at the terminal count. A large divisor of 200 catches counter width or wrap errors. Other pairs are out of range (select 0 and 15, divisor 0 and 3), so a missing clamp shows up as a wrong period. For each pair the first basic tick, the first ready, two mid ticks and two bit ticks are timed from the restart, which tells a prescaler fault from a divider or phase fault. Directed cases cover reset, holding and re-enabling the channel, and a divisor write in the middle of a run.

// File: rtl/bitgen_pkg.sv
package bitgen_pkg;

    // Registered output bundle shared by the divider stage.
    typedef struct packed {
        logic basic_tk;
        logic mid_tk;
        logic bit_tk;
    } tick_t;

    // Smallest select that keeps sys_hz >> k at or below max_hz, capped.
    function automatic int min_sel(input int sys_hz, input int max_hz, input int cap);
        int k;
        int f;
        k = 0;
        f = sys_hz;
        for (int i = 0; i < 32; i++) begin
            if (f > max_hz && k < cap) begin
                f = f >> 1;
                k = k + 1;
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/bg_cfg.sv
module bg_cfg #(
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 11,
    parameter int MIN_SEL = 1,
    parameter int MIN_CNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] divn
);
    localparam logic [SEL_W-1:0]  SEL_HI = SEL_W'(MAX_SEL);
    localparam logic [SEL_W-1:0]  SEL_LO = SEL_W'(MIN_SEL);
    localparam logic [DATA_W-1:0] CNT_LO = DATA_W'(MIN_CNT);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] cnt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [SEL_W-1:0] sel_raw;

    assign sel_raw = wr_data[SEL_W-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (!wr_addr) begin
                if (sel_raw > SEL_HI)      cfg_d.sel = SEL_HI;
                else if (sel_raw < SEL_LO) cfg_d.sel = SEL_LO;
                else                       cfg_d.sel = sel_raw;
            end else begin
                if (wr_data < CNT_LO) cfg_d.cnt = CNT_LO;
                else                  cfg_d.cnt = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sel <= SEL_LO;
            cfg_q.cnt <= CNT_LO;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel  = cfg_q.sel;
    assign divn = cfg_q.cnt;
endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
    parameter int SEL_W = 4,
    parameter int PRE_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             basic_evt
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] limit;

    // 2^sel - 1 as a mask of low ones
    assign limit = ~({PRE_W{1'b1}} << sel);

    always_comb begin
        basic_evt = 1'b0;
        pre_d     = pre_q + 1'b1;
        if (restart) begin
            pre_d = '0;
        end else if (pre_q == limit) begin
            basic_evt = 1'b1;
            pre_d     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/bg_divider.sv
module bg_divider
    import bitgen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             basic_evt,
    input  logic [CNT_W-1:0] divn,
    output logic             basic_tick,
    output logic             mid_tick,
    output logic             bit_tick,
    output logic             ready
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             half;
        logic [1:0]       seen;
        logic             rdy;
        tick_t            tk;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.tk = '0;
        if (restart) begin
            st_d = '0;
        end else if (basic_evt) begin
            st_d.tk.basic_tk = 1'b1;
            if (st_q.seen != 2'd2) st_d.seen = st_q.seen + 2'd1;
            if (st_q.seen == 2'd1) st_d.rdy = 1'b1;
            if (st_q.cnt == divn - 1'b1) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
                if (st_q.half) st_d.tk.bit_tk = 1'b1;
                else           st_d.tk.mid_tk = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign basic_tick = st_q.tk.basic_tk;
    assign mid_tick   = st_q.tk.mid_tk;
    assign bit_tick   = st_q.tk.bit_tk;
    assign ready      = st_q.rdy;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import bitgen_pkg::*;
#(
    parameter int SYS_HZ       = 50_000_000,
    parameter int MAX_BASIC_HZ = 25_000_000,
    parameter int DATA_W       = 8,
    parameter int SEL_W        = 4,
    parameter int MAX_SEL      = 11,
    parameter int MIN_CNT      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              basic_tick,
    output logic              mid_tick,
    output logic              bit_tick,
    output logic              ready
);
    localparam int MIN_SEL = min_sel(SYS_HZ, MAX_BASIC_HZ, MAX_SEL);
    localparam int PRE_W   = (MAX_SEL < 1) ? 1 : MAX_SEL;

    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] divn;
    logic              restart;
    logic              basic_evt;

    assign restart = wr_en | ~chan_en;

    bg_cfg #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .MAX_SEL(MAX_SEL),
        .MIN_SEL(MIN_SEL),
        .MIN_CNT(MIN_CNT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .sel    (sel),
        .divn   (divn)
    );

    bg_prescaler #(
        .SEL_W(SEL_W),
        .PRE_W(PRE_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sel      (sel),
        .basic_evt(basic_evt)
    );

    bg_divider #(
        .CNT_W(DATA_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .basic_evt (basic_evt),
        .divn      (divn),
        .basic_tick(basic_tick),
        .mid_tick  (mid_tick),
        .bit_tick  (bit_tick),
        .ready     (ready)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic wr_en,
    input logic basic_tick,
    input logic mid_tick,
    input logic bit_tick,
    input logic ready
);
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !(basic_tick || mid_tick || bit_tick || ready));

    a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!basic_tick && !ready));

    a_r4_mid_not_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !(mid_tick && bit_tick));

    a_r3_bit_on_basic: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> basic_tick);

    a_r9_ready_rises_on_basic: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> basic_tick);

    a_r9_bit_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> ready);

    a_r10_bit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .wr_en     (wr_en),
    .basic_tick(basic_tick),
    .mid_tick  (mid_tick),
    .bit_tick  (bit_tick),
    .ready     (ready)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       basic_tick, mid_tick, bit_tick, ready;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .basic_tick(basic_tick),
        .mid_tick(mid_tick), .bit_tick(bit_tick), .ready(ready)
    );

    // written select, written divisor, expected prescale period, expected divisor
    localparam int NV = 8;
    localparam int V_SEL [NV] = '{1, 2, 0, 3, 1, 1, 4, 15};
    localparam int V_DIV [NV] = '{8, 9, 8, 13, 3, 0, 200, 8};
    localparam int V_P   [NV] = '{2, 4, 2, 8, 2, 2, 16, 2048};
    localparam int V_N   [NV] = '{8, 9, 8, 13, 8, 8, 200, 8};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called at the negedge of cycle 0 after a restart.
    task automatic measure(input string tag, input int p, input int n);
        int f_basic = -1, f_rdy = -1, m1 = -1, m2 = -1, b1 = -1, b2 = -1;
        int both = 0;
        int lim = 4 * n * p + 4;
        for (int t = 0; t <= lim; t++) begin
            if (basic_tick && f_basic < 0) f_basic = t;
            if (ready && f_rdy < 0) f_rdy = t;
            if (mid_tick) begin
                if (m1 < 0) m1 = t; else if (m2 < 0) m2 = t;
            end
            if (bit_tick) begin
                if (b1 < 0) b1 = t; else if (b2 < 0) b2 = t;
            end
            if (mid_tick && bit_tick) both++;
            if (b2 >= 0) break;
            @(negedge clk);
        end
        chk({"R2 first basic ", tag}, f_basic, p);
        chk({"R9 ready ", tag}, f_rdy, 2 * p);
        chk({"R4 first mid ", tag}, m1, n * p);
        chk({"R4 second mid ", tag}, m2, 3 * n * p);
        chk({"R3 first bit ", tag}, b1, 2 * n * p);
        chk({"R3 second bit ", tag}, b2, 4 * n * p);
        chk({"R4 mid with bit ", tag}, both, 0);
    endtask

    task automatic run_all();
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {basic_tick, mid_tick, bit_tick, ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {basic_tick, mid_tick, bit_tick, ready}, 0);
        chan_en = 1'b1;

        // Vector table: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, V_SEL[i]);
            wr(1'b1, V_DIV[i]);
            measure($sformatf("vec%0d", i), V_P[i], V_N[i]);
        end

        // R7: divisor write in the middle of a run
        wr(1'b0, 1);
        wr(1'b1, 8);
        repeat (21) @(negedge clk);
        wr(1'b1, 10);
        measure("midrun R7", 2, 10);

        // R8: disabled channel stays quiet and keeps config writes
        @(negedge clk);
        chan_en = 1'b0;
        begin
            int act = 0;
            for (int t = 0; t < 60; t++) begin
                @(negedge clk);
                act += int'(basic_tick) + int'(mid_tick) + int'(bit_tick) + int'(ready);
            end
            chk("R8 outputs while disabled", act, 0);
        end
        wr(1'b0, 2);
        wr(1'b1, 11);
        @(negedge clk);
        chk("R8 no ticks after writes while off", {basic_tick, mid_tick, bit_tick, ready}, 0);
        chan_en = 1'b1;
        measure("reenable R8", 4, 11);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule